// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This controller gathers interrupt requests from a set of on-chip and external sources and drives one interrupt line to a processor core. Next to that line it gives the number of the source that wins arbitration among all requests that are both pending and enabled. Software works through four registers on a simple read/write port:

- a pending register, where it acknowledges edge requests by writing ones;
- an enable (mask) register;
- a highest-priority selector;
- a slot map that places the mappable sources into the priority table.

Sources are numbered from 0. The first `NUM_MAP` sources are the mappable ones: five external lines, a periodic timer, a timer counter and a bus interrupt source. Each of them can be placed in any slot of the table. The remaining `NUM_FIX` sources have fixed priority in ascending index order. The mix includes the two external lines that cannot be remapped.

The `SPREAD` parameter selects how slots and fixed sources are laid out in the table. This choice is made when the block is built. The highest-priority selector can be rewritten at any time. A disabled source still records its request, so software can poll the pending register with every source disabled.

Top module: `prio_irq_ctrl`

## Requirements
- R1: `irq_out` is 1 exactly when at least one source is both pending and enabled. Mask bit value 1 enables a source and 0 disables it.
- R2: Pending bits are set whatever the mask holds. With the mask all zero, `irq_out` and `vec_valid` stay 0 while the pending register (address 0) still shows the requests.
- R3: For a level source, the pending bit equals the request sampled at the previous rising clock edge. Writes to its pending bit have no effect.
- R4: For an edge source (set bit in `EDGE_SRC`), the pending bit is set after a 0-to-1 request transition seen at a clock edge, and holds after the request falls. Writing 1 to that bit at address 0 clears it, and writing 0 leaves it set. A new transition in the same cycle as a clearing write leaves the bit set.
- R5: When any source is pending and enabled, `vec_valid` is 1 and `vec_id` gives the winning source number. Otherwise both are 0.
- R6: The selector is at address 2, bits [IDW-1:0], with reset value 0. If the source it names is pending and enabled, that source wins over every other source from the cycle after the write that set it. A value of `NUM_SRC` or above disables the override.
- R7: With `SPREAD`=0, the priority order is slot 0 first, then slots 1 to `NUM_MAP`-1, then fixed sources in ascending index. Slot k is bits [k*MW+MW-1:k*MW] of address 3 and holds the number of a mappable source. Its reset value is k.
- R8: With `SPREAD`=1, the order alternates slot 0, first fixed source, slot 1, second fixed source, and so on. Whatever remains of the longer group follows in order.
- R9: When the override source is not pending or not enabled, the vector follows the normal order in the same cycle, with no added latency.
- R10: Reset clears pending, mask and selector, loads the slot map with slot k = k, and drives `irq_out`, `vec_valid` and `vec_id` to 0.
- R11: The mask register at address 1 reads back the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 pending, 1 mask, 2 selector, 3 slot map |
| wr_data | input | DW | Write data |
| rd_data | output | DW | Read data for `addr` (combinational) |
| req | input | NUM_SRC | Raw interrupt requests, one per source |
| irq_out | output | 1 | Interrupt to the core |
| vec_valid | output | 1 | `vec_id` is meaningful |
| vec_id | output | IDW | Number of the winning source |

## Verification
The bench builds two copies with `NUM_MAP`=8 and `NUM_FIX`=3, so there are eleven sources. Sources 2 and 10 are edge type, which puts one edge source among the mappable slots and one among the fixed sources. One copy is built with `SPREAD`=0 and the other with `SPREAD`=1. Both copies receive the same stimulus. A sweep goes through request patterns, mask values, every selector value including the disabled ones, and slot maps formed as affine permutations. This brings every layout of the table and every override case within reach. Directed sequences cover acknowledge, the ordering of a new edge against a clear, and polling with all sources disabled.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NUM_MAP = 8,
  parameter int NUM_FIX = 6,
  parameter bit SPREAD = 1'b0,
  parameter logic [NUM_MAP+NUM_FIX-1:0] EDGE_SRC = '0,
  localparam int NUM_SRC = NUM_MAP + NUM_FIX,
  localparam int IDW = $clog2(NUM_SRC),
  localparam int MW = $clog2(NUM_MAP),
  localparam int DW = (NUM_SRC > NUM_MAP*MW) ? NUM_SRC : NUM_MAP*MW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [1:0]         addr,
  input  logic [DW-1:0]      wr_data,
  output logic [DW-1:0]      rd_data,
  input  logic [NUM_SRC-1:0] req,
  output logic               irq_out,
  output logic               vec_valid,
  output logic [IDW-1:0]     vec_id
);
  localparam int MINC = (NUM_MAP < NUM_FIX) ? NUM_MAP : NUM_FIX;

  logic [NUM_SRC-1:0]    req_q, pend, mask, act;
  logic [IDW-1:0]        ovr, win;
  logic [NUM_MAP*MW-1:0] smap;

  wire wr_pend = wr_en && addr == 2'd0;

  function automatic logic [NUM_MAP*MW-1:0] ident_map();
    logic [NUM_MAP*MW-1:0] r;
    for (int k = 0; k < NUM_MAP; k++) r[k*MW +: MW] = MW'(k);
    return r;
  endfunction

  function automatic bit pos_is_slot(int p);
    if (!SPREAD) return p < NUM_MAP;
    if (p < 2*MINC) return (p % 2) == 0;
    return NUM_MAP > NUM_FIX;
  endfunction

  function automatic int pos_idx(int p);
    if (!SPREAD) return (p < NUM_MAP) ? p : p - NUM_MAP;
    if (p < 2*MINC) return p / 2;
    return p - MINC;
  endfunction

  always_ff @(posedge clk)
    if (rst) req_q <= '0;
    else     req_q <= req;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (EDGE_SRC[i]) begin : g_edge
      logic hold;
      always_ff @(posedge clk)
        if (rst) hold <= 1'b0;
        else     hold <= (req[i] & ~req_q[i]) | (hold & ~(wr_pend & wr_data[i]));
      assign pend[i] = hold;
      a_r4_edge_latch: assert property (@(posedge clk) disable iff (rst)
        (req[i] && !req_q[i]) |=> pend[i]);
    end else begin : g_lvl
      assign pend[i] = req_q[i];
      a_r3_level_follow: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> pend[i] == $past(req[i]));
    end
  end

  always_ff @(posedge clk)
    if (rst) begin
      mask <= '0;
      ovr  <= '0;
      smap <= ident_map();
    end else if (wr_en) begin
      if (addr == 2'd1) mask <= wr_data[NUM_SRC-1:0];
      if (addr == 2'd2) ovr  <= wr_data[IDW-1:0];
      if (addr == 2'd3) smap <= wr_data[NUM_MAP*MW-1:0];
    end

  always_comb
    case (addr)
      2'd0:    rd_data = DW'(pend);
      2'd1:    rd_data = DW'(mask);
      2'd2:    rd_data = DW'(ovr);
      default: rd_data = DW'(smap);
    endcase

  assign act = pend & mask;

  always_comb begin
    int sid;
    win = '0;
    for (int s = NUM_SRC-1; s >= 0; s--)
      if (act[s]) win = IDW'(s);
    for (int p = NUM_SRC-1; p >= 0; p--) begin
      if (pos_is_slot(p)) sid = int'(smap[(pos_idx(p) % NUM_MAP)*MW +: MW]);
      else                sid = NUM_MAP + (pos_idx(p) % NUM_FIX);
      if (act[sid]) win = IDW'(sid);
    end
    if (int'(ovr) < NUM_SRC && act[ovr]) win = ovr;
  end

  assign irq_out   = |act;
  assign vec_valid = |act;
  assign vec_id    = win;

  a_r5_vec_active: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> (pend[vec_id] && mask[vec_id]));
  a_r6_override_wins: assert property (@(posedge clk) disable iff (rst)
    (int'(ovr) < NUM_SRC && pend[ovr] && mask[ovr]) |-> vec_id == ovr);
  a_r1_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> mask != '0);
  a_r2_mask_off_quiet: assert property (@(posedge clk) disable iff (rst)
    (mask == '0) |-> (!irq_out && !vec_valid));
endmodule

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb_top;
  localparam int NS = 11;
  localparam logic [NS-1:0] EDGES = 11'b100_0000_0100;

  logic clk = 0, rst = 1, wr_en = 0;
  logic [1:0] addr = 0;
  logic [23:0] wr_data = 0, rd_data, rd_unused;
  logic [NS-1:0] req = 0;
  logic irq_g, vv_g, irq_s, vv_s;
  logic [3:0] vid_g, vid_s;
  int nchk = 0, nfail = 0;
  logic [NS-1:0] cur_mask = 0;
  int cur_ovr = 0;
  logic [23:0] cur_sm;

  always #2.5 clk = ~clk;

  prio_irq_ctrl #(.NUM_MAP(8), .NUM_FIX(3), .SPREAD(1'b0), .EDGE_SRC(EDGES)) dut_i (
    .clk, .rst, .wr_en, .addr, .wr_data, .rd_data, .req,
    .irq_out(irq_g), .vec_valid(vv_g), .vec_id(vid_g));
  prio_irq_ctrl #(.NUM_MAP(8), .NUM_FIX(3), .SPREAD(1'b1), .EDGE_SRC(EDGES)) dut_sp (
    .clk, .rst, .wr_en, .addr, .wr_data, .rd_data(rd_unused), .req,
    .irq_out(irq_s), .vec_valid(vv_s), .vec_id(vid_s));

  task automatic chk(string r, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  function automatic logic [23:0] perm(int a, int b);
    logic [23:0] m;
    for (int k = 0; k < 8; k++) m[k*3 +: 3] = 3'((k*a + b) % 8);
    return m;
  endfunction

  function automatic int exp_win(logic [NS-1:0] act, int ov, logic [23:0] sm, bit sp);
    int ord[NS];
    if (act == 0) return -1;
    if (ov < NS && act[ov]) return ov;
    for (int p = 0; p < NS; p++)
      if (!sp) ord[p] = (p < 8) ? int'(sm[p*3 +: 3]) : p;
      else if (p < 6) ord[p] = (p % 2 == 0) ? int'(sm[(p/2)*3 +: 3]) : 8 + p/2;
      else ord[p] = int'(sm[(p-3)*3 +: 3]);
    for (int p = 0; p < NS; p++) if (act[ord[p]]) return ord[p];
    return -1;
  endfunction

  task automatic rd(logic [1:0] a, output logic [23:0] d);
    addr = a; #0.5; d = rd_data;
  endtask

  task automatic wr(logic [1:0] a, logic [23:0] d);
    @(negedge clk); wr_en = 1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 0; addr = 0; wr_data = 0;
    if (a == 1) cur_mask = d[NS-1:0];
    if (a == 2) cur_ovr = int'(d[3:0]);
    if (a == 3) cur_sm = d;
  endtask

  task automatic chk_vec(string r, logic [NS-1:0] pend_e);
    logic [NS-1:0] a = pend_e & cur_mask;
    int eg = exp_win(a, cur_ovr, cur_sm, 1'b0);
    int es = exp_win(a, cur_ovr, cur_sm, 1'b1);
    chk({r, " R1 irq"}, int'(irq_g), int'(a != 0));
    chk({r, " R5 valid"}, int'(vv_g), int'(a != 0));
    chk({r, " R7 grouped id"}, int'(vid_g), eg < 0 ? 0 : eg);
    chk({r, " R8 spread id"}, int'(vid_s), es < 0 ? 0 : es);
    chk({r, " R1 spread irq"}, int'(irq_s), int'(a != 0));
    chk({r, " R5 spread valid"}, int'(vv_s), int'(a != 0));
  endtask

  task automatic drop_all();
    @(negedge clk); req = 0;
    wr(0, 24'hFFFFFF);
  endtask

  initial begin
    #(5.0 * 150000);
    nfail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [23:0] d;
    cur_sm = perm(1, 0);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    chk("R10 irq", int'(irq_g), 0);
    chk("R10 valid", int'(vv_g), 0);
    chk("R10 id", int'(vid_g), 0);
    rd(0, d); chk("R10 pend", int'(d), 0);
    rd(1, d); chk("R10 mask", int'(d), 0);
    rd(2, d); chk("R10 ovr", int'(d), 0);
    rd(3, d); chk("R10 slot map", int'(d), int'(perm(1, 0)));
    // R11 mask readback
    wr(1, 24'h5A5);
    rd(1, d); chk("R11 mask", int'(d), 'h5A5);
    // R2 polling with all disabled
    wr(1, 0);
    req = 11'h6B3; @(negedge clk);
    rd(0, d); chk("R2 pend polled", int'(d), 'h6B3);
    chk("R2 irq quiet", int'(irq_g), 0);
    chk("R2 valid quiet", int'(vv_g), 0);
    drop_all();
    // R4 edge latch, hold, clear
    wr(1, 24'h7FF);
    req[2] = 1; @(negedge clk); req[2] = 0; @(negedge clk);
    rd(0, d); chk("R4 edge holds", int'(d[2]), 1);
    chk("R4 edge irq", int'(irq_g), 1);
    wr(0, 24'h0); rd(0, d); chk("R4 write0 keeps", int'(d[2]), 1);
    wr(0, 24'h4); rd(0, d); chk("R4 write1 clears", int'(d[2]), 0);
    chk("R4 irq after clear", int'(irq_g), 0);
    @(negedge clk); req[2] = 1; wr_en = 1; addr = 0; wr_data = 24'h4;
    @(negedge clk); wr_en = 0; wr_data = 0;
    rd(0, d); chk("R4 set beats clear", int'(d[2]), 1);
    drop_all();
    rd(0, d); chk("R4 cleared", int'(d), 0);
    // R3 level write ignored
    req[0] = 1; @(negedge clk);
    wr(0, 24'h1); rd(0, d); chk("R3 level ignores write", int'(d[0]), 1);
    req[0] = 0; @(negedge clk);
    rd(0, d); chk("R3 level follows", int'(d[0]), 0);
    // R6 / R9 override
    req = 11'h021; @(negedge clk);
    chk_vec("R6 before", 11'h021);
    chk("R6 default winner", int'(vid_g), 0);
    wr(2, 24'd5);
    chk("R6 override applied", int'(vid_g), 5);
    chk("R6 spread override", int'(vid_s), 5);
    wr(2, 24'd15);
    chk("R6 override disabled", int'(vid_g), 0);
    wr(2, 24'd9);
    chk("R9 override not pending", int'(vid_g), 0);
    wr(2, 24'd5); wr(1, 24'h7DF);
    chk("R9 override masked", int'(vid_g), 0);
    wr(1, 24'h7FF);
    chk("R6 override unmasked", int'(vid_g), 5);
    wr(2, 0);
    drop_all();
    // R7 vs R8 layout
    req = 11'h102; @(negedge clk);
    chk("R7 slot before fixed", int'(vid_g), 1);
    chk("R8 fixed between slots", int'(vid_s), 8);
    drop_all();
    // sweep
    for (int it = 0; it < 400; it++) begin
      logic [NS-1:0] pat = NS'((it * 1237 + 91) ^ (it * it * 7));
      wr(1, 24'((~(it * 613)) & 'h7FF));
      wr(2, 24'(it % 16));
      wr(3, perm(2 * (it % 4) + 1, (it / 4) % 8));
      req = pat; @(negedge clk);
      rd(0, d); chk("R2 sweep pend", int'(d), int'(pat));
      chk_vec("sweep", pat);
      drop_all();
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule